// File: doc/BRIEF.md
# ALU Status Flags Register

This block is the condition-code register of a small processor core. Each cycle it can take one add, subtract or bitwise operation on 8-, 16- or 32-bit operands. It forms the result internally and derives the arithmetic status bits from it. It keeps those bits, three control bits and a set of plain storage bits in one 32-bit status word. Each bit has a fixed position in that word.

The control bits are single-step (trap), interrupt enable and string direction. They move only through explicit set/clear commands. Software can also replace the whole word in one write. A fixed mask keeps the reserved positions at their constant values. Every update lands on the clock edge where its request is valid. A full-word write in the same cycle as an operation or command takes precedence over both.

Top module: `alu_flag_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads the status word with 0x00000002.
- R2: Bit 1 of `flags_q` always reads 1. Bits 3, 5, 15 and 22..31 always read 0, and writes to them are ignored.
- R3: When `wr_en` is high, the next status word takes `wr_data` in bits 0, 2, 4, 6..14 and 16..21, which gives a writable mask of 0x003F7FD5. The bit positions are carry 0, parity 2, half-carry 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10 and overflow 11.
- R4: A full-word write in the same cycle as an operation or a control command wins over both.
- R5: The carry bit (bit 0) is set on an add carry out of, or a subtract borrow out of, the top bit of the selected width. `op_size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R6: The half-carry bit (bit 4) is set on a carry out of bit 3 for add, or a borrow into bit 3 for subtract.
- R7: The zero bit (bit 6) is set when the width-masked result is zero, and the sign bit (bit 7) copies the result's top bit.
- R8: The parity bit (bit 2) is set when the low 8 bits of the result hold an even number of ones.
- R9: The overflow bit (bit 11) is set on signed overflow. For add, this means the operand signs agree and the result sign differs. For subtract, it means the operand signs differ and the result sign differs from `opa`.
- R10: The bitwise operations (`op_code` 2 = AND, 3 = OR, 4 = XOR) clear carry and overflow, leave half-carry unchanged, and update zero, sign and parity.
- R11: `ctl_valid` with `ctl_sel` 0/1/2 loads `ctl_val` into trap/interrupt enable/direction (bits 8/9/10). `ctl_sel` 3 does nothing. Arithmetic never changes these bits.
- R12: Bits 12..14 and 16..21 are plain storage and change only by a full-word write.
- R13: `op_code` values 5..7 update no bit of the status word.
- R14: `result` shows the width-masked result of `op_code` 0 = ADD, 1 = SUB, 2 = AND, 3 = OR, 4 = XOR in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand width select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| ctl_valid | input | 1 | Control-bit command present |
| ctl_sel | input | 2 | Control bit select |
| ctl_val | input | 1 | Value for the selected control bit |
| wr_en | input | 1 | Full-word write |
| wr_data | input | 32 | Full-word write data |
| result | output | 32 | Width-masked operation result |
| flags_q | output | 32 | Status word |

## Verification
The only parameter is the 32-bit word width in the package, because the bit layout depends on it. The bench builds the block with that default. The default brings all three operand widths within reach: carries and overflows at bit 7, bit 15 and bit 31 all come up in random traffic. Directed cases cover the wrap to zero at each width, overflow on subtract, a write colliding with an operation, and undefined op codes.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
    localparam int XLEN = 32;
    localparam int NIB  = 4;
    localparam int PBITS = 8;

    localparam int CF_B = 0;
    localparam int PF_B = 2;
    localparam int AF_B = 4;
    localparam int ZF_B = 6;
    localparam int SF_B = 7;
    localparam int TF_B = 8;
    localparam int IE_B = 9;
    localparam int DF_B = 10;
    localparam int OF_B = 11;

    localparam logic [XLEN-1:0] WR_MASK    = 32'h003F_7FD5;
    localparam logic [XLEN-1:0] FIXED_ONES = 32'h0000_0002;
    localparam logic [XLEN-1:0] RESET_VAL  = 32'h0000_0002;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CTL_TRAP = 2'd0,
        CTL_IE   = 2'd1,
        CTL_DIR  = 2'd2,
        CTL_NONE = 2'd3
    } ctl_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } stat_t;
endpackage

// File: rtl/flag_alu.sv
module flag_alu
    import flagreg_pkg::*;
(
    input  logic [2:0]      op_code,
    input  logic [1:0]      op_size,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] res,
    output stat_t           st,
    output logic            upd,
    output logic            is_logic
);
    logic [XLEN-1:0] wmask;
    logic [5:0]      msb;
    logic [XLEN-1:0] am, bm, hx;
    logic [XLEN:0]   wide;
    logic            sa, sb, sr;

    always_comb begin
        unique case (op_size)
            2'd0:    begin wmask = 32'h0000_00FF; msb = 6'd7;  end
            2'd1:    begin wmask = 32'h0000_FFFF; msb = 6'd15; end
            default: begin wmask = '1;            msb = 6'd31; end
        endcase
        am = opa & wmask;
        bm = opb & wmask;
        upd = 1'b1;
        is_logic = 1'b0;
        unique case (op_code)
            OP_ADD: wide = {1'b0, am} + {1'b0, bm};
            OP_SUB: wide = {1'b0, am} - {1'b0, bm};
            OP_AND: begin wide = {1'b0, am & bm}; is_logic = 1'b1; end
            OP_OR:  begin wide = {1'b0, am | bm}; is_logic = 1'b1; end
            OP_XOR: begin wide = {1'b0, am ^ bm}; is_logic = 1'b1; end
            default: begin wide = '0; upd = 1'b0; end
        endcase
        res = wide[XLEN-1:0] & wmask;
        hx  = am ^ bm ^ res;
        sa  = am[msb[4:0]];
        sb  = bm[msb[4:0]];
        sr  = res[msb[4:0]];

        st.zf = (res == '0);
        st.sf = sr;
        st.pf = ~^res[PBITS-1:0];
        st.af = hx[NIB];
        if (op_code == OP_SUB) begin
            st.cf = (am < bm);
            st.of = (sa != sb) && (sr != sa);
        end else begin
            st.cf = wide[msb + 6'd1];
            st.of = (sa == sb) && (sr != sa);
        end
    end
endmodule

// File: rtl/flag_merge.sv
module flag_merge
    import flagreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic            upd,
    input  logic            is_logic,
    input  stat_t           st,
    input  logic            ctl_valid,
    input  logic [1:0]      ctl_sel,
    input  logic            ctl_val,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] flags_q
);
    logic [XLEN-1:0] word_q, word_d, raw;

    always_comb begin
        raw = word_q;
        if (op_valid && upd) begin
            raw[ZF_B] = st.zf;
            raw[SF_B] = st.sf;
            raw[PF_B] = st.pf;
            if (is_logic) begin
                raw[CF_B] = 1'b0;
                raw[OF_B] = 1'b0;
            end else begin
                raw[CF_B] = st.cf;
                raw[OF_B] = st.of;
                raw[AF_B] = st.af;
            end
        end
        if (ctl_valid) begin
            unique case (ctl_sel)
                CTL_TRAP: raw[TF_B] = ctl_val;
                CTL_IE:   raw[IE_B] = ctl_val;
                CTL_DIR:  raw[DF_B] = ctl_val;
                default:  ;
            endcase
        end
        if (wr_en) raw = wr_data;
        word_d = (raw & WR_MASK) | FIXED_ONES;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= RESET_VAL;
        else     word_q <= word_d;
    end

    assign flags_q = word_q;

    // R4
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> flags_q == (($past(wr_data) & WR_MASK) | FIXED_ONES));

    // R10
    logic_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && upd && is_logic && !wr_en) |=>
            (!flags_q[CF_B] && !flags_q[OF_B] && $stable(flags_q[AF_B])));

    // R11
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_valid && !wr_en) |=> $stable(flags_q[DF_B:TF_B]));

    // R12
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flags_q[21:12]));
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import flagreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [1:0]      op_size,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            ctl_valid,
    input  logic [1:0]      ctl_sel,
    input  logic            ctl_val,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] result,
    output logic [XLEN-1:0] flags_q
);
    stat_t st;
    logic  upd, is_logic;

    flag_alu u_alu (
        .op_code  (op_code),
        .op_size  (op_size),
        .opa      (opa),
        .opb      (opb),
        .res      (result),
        .st       (st),
        .upd      (upd),
        .is_logic (is_logic)
    );

    flag_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .upd       (upd),
        .is_logic  (is_logic),
        .st        (st),
        .ctl_valid (ctl_valid),
        .ctl_sel   (ctl_sel),
        .ctl_val   (ctl_val),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .flags_q   (flags_q)
    );

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && upd && !wr_en) |=> flags_q[ZF_B] == ($past(result) == '0));

    // R13
    undef_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !upd && !ctl_valid && !wr_en) |=> $stable(flags_q));
endmodule

// File: tb/sim_alu_flag_reg.sv
module sim_alu_flag_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, ctl_valid, ctl_val, wr_en;
    logic [2:0]  op_code;
    logic [1:0]  op_size, ctl_sel;
    logic [31:0] opa, opb, wr_data, result, flags_q;
    logic [31:0] model;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alu_flag_reg u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .opa(opa), .opb(opb), .ctl_valid(ctl_valid),
        .ctl_sel(ctl_sel), .ctl_val(ctl_val), .wr_en(wr_en),
        .wr_data(wr_data), .result(result), .flags_q(flags_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int wid(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    function automatic longint unsigned msk(input logic [1:0] sz);
        return (longint'(1) << wid(sz)) - 1;
    endfunction

    function automatic logic [31:0] m_res(input logic [2:0] op, input logic [1:0] sz,
                                          input logic [31:0] a, input logic [31:0] b);
        longint unsigned ua, ub, r;
        ua = a & msk(sz);
        ub = b & msk(sz);
        case (op)
            3'd0: r = ua + ub;
            3'd1: r = ua - ub;
            3'd2: r = ua & ub;
            3'd3: r = ua | ub;
            3'd4: r = ua ^ ub;
            default: r = 0;
        endcase
        return 32'(r & msk(sz));
    endfunction

    function automatic logic [31:0] m_next(input logic [31:0] cur);
        logic [31:0] n;
        longint unsigned ua, ub, r;
        int w;
        logic sa, sb, sr;
        n = cur;
        if (op_valid && op_code <= 3'd4) begin
            w  = wid(op_size);
            ua = opa & msk(op_size);
            ub = opb & msk(op_size);
            r  = m_res(op_code, op_size, opa, opb);
            sa = ua[w-1]; sb = ub[w-1]; sr = r[w-1];
            n[6] = (r == 0);
            n[7] = sr;
            n[2] = ($countones(r[7:0]) % 2) == 0;
            if (op_code == 3'd0) begin
                n[0]  = ((ua + ub) >> w) != 0;
                n[4]  = ((ua & 15) + (ub & 15)) > 15;
                n[11] = (sa == sb) && (sr != sa);
            end else if (op_code == 3'd1) begin
                n[0]  = ua < ub;
                n[4]  = (ua & 15) < (ub & 15);
                n[11] = (sa != sb) && (sr != sa);
            end else begin
                n[0] = 1'b0;
                n[11] = 1'b0;
            end
        end
        if (ctl_valid && ctl_sel != 2'd3) n[8 + ctl_sel] = ctl_val;
        if (wr_en) n = (wr_data & 32'h003F7FD5) | 32'h2;
        return n;
    endfunction

    task automatic idle();
        op_valid = 0; op_code = 0; op_size = 0; opa = 0; opb = 0;
        ctl_valid = 0; ctl_sel = 0; ctl_val = 0; wr_en = 0; wr_data = 0;
    endtask

    task automatic step();
        logic [31:0] nxt;
        #1;
        if (op_valid && op_code <= 3'd4)
            chk("R14 result", result, m_res(op_code, op_size, opa, opb));
        nxt = m_next(model);
        @(posedge clk); #1;
        model = nxt;
        chk("R5 carry", {31'b0, flags_q[0]}, {31'b0, model[0]});
        chk("R8 parity", {31'b0, flags_q[2]}, {31'b0, model[2]});
        chk("R6 half-carry", {31'b0, flags_q[4]}, {31'b0, model[4]});
        chk("R7 zero/sign", {30'b0, flags_q[7:6]}, {30'b0, model[7:6]});
        chk("R9 overflow", {31'b0, flags_q[11]}, {31'b0, model[11]});
        chk("R11 control", {29'b0, flags_q[10:8]}, {29'b0, model[10:8]});
        chk("R12 storage", flags_q & 32'h003F7000, model & 32'h003F7000);
        chk("R2 fixed bits", flags_q & 32'hFFC0802A, 32'h2);
    endtask

    task automatic op(input logic [2:0] c, input logic [1:0] s, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk); idle();
        op_valid = 1; op_code = c; op_size = s; opa = a; opb = b;
        step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst = 1;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 reset", flags_q, 32'h2);
        model = 32'h2;
        @(negedge clk); rst = 0;

        // R5 R6 R7 R8: 8-bit wrap to zero
        op(3'd0, 2'd0, 32'hFF, 32'h01);
        chk("R5 R7 R6 R8 add8 wrap", flags_q & 32'hFFF, 32'h057);
        // R9 subtract overflow
        op(3'd1, 2'd0, 32'h80, 32'h01);
        chk("R9 sub8 overflow", flags_q & 32'h8D5, 32'h810);
        // 16 and 32 bit carry out
        op(3'd0, 2'd1, 32'hFFFF, 32'h1);
        op(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1);
        chk("R5 add32 carry", {31'b0, flags_q[0]}, 32'h1);
        // R10 logic: AF held from previous add (set)
        op(3'd4, 2'd2, 32'h1234, 32'h1234);
        chk("R10 xor clears CF/OF keeps AF", flags_q & 32'h8D5, 32'h054);
        // R3 full write
        @(negedge clk); idle(); wr_en = 1; wr_data = 32'hFFFF_FFFF; step();
        chk("R3 full write", flags_q, 32'h003F7FD7);
        // R4 write with op and ctl
        @(negedge clk); idle(); wr_en = 1; wr_data = 32'h0;
        op_valid = 1; op_code = 3'd0; opa = 32'hFF; opb = 32'h1;
        ctl_valid = 1; ctl_sel = 2'd0; ctl_val = 1; step();
        chk("R4 write wins", flags_q, 32'h2);
        // R11 control commands
        @(negedge clk); idle(); ctl_valid = 1; ctl_sel = 2'd2; ctl_val = 1; step();
        chk("R11 set direction", flags_q, 32'h402);
        @(negedge clk); idle(); ctl_valid = 1; ctl_sel = 2'd3; ctl_val = 1; step();
        chk("R11 sel 3 ignored", flags_q, 32'h402);
        // R13 undefined op
        op(3'd6, 2'd0, 32'h0, 32'h0);
        chk("R13 undefined op", flags_q, 32'h402);

        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); idle();
            op_valid  = ($urandom % 5) != 0;
            op_code   = 3'($urandom % 8);
            op_size   = 2'($urandom % 4);
            opa       = $urandom;
            opb       = ($urandom % 4 == 0) ? opa : $urandom;
            ctl_valid = ($urandom % 5) == 0;
            ctl_sel   = 2'($urandom % 4);
            ctl_val   = 1'($urandom);
            wr_en     = ($urandom % 20) == 0;
            wr_data   = $urandom;
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule